// File: doc/BRIEF.md
# Turn-Model Route Selector for a 2D Mesh

This unit decides where a packet goes next inside one router of a two-dimensional mesh. It is given the router's own column and row, the packet's destination column and row, and the direction the packet was moving when it arrived. It is also given one busy flag for each of the four mesh outputs. From these it forms the set of output directions that shorten the remaining path and that the selected turn policy permits. It then chooses one of them and prefers an output that is not busy.

There are five selectable policies. Dimension order is the only non-adaptive one. West-first, north-last and negative-first each forbid two of the eight right-angle turns. Odd-even forbids different turns depending on the parity of the current column. A request is sampled on a clock edge. The permitted set and the choice appear on registered outputs one cycle later, with a valid flag.

The control is a two-state machine. RS_IDLE means no result is being presented. RS_ISSUE means the registered result belongs to the request sampled at the previous edge. The transition IDLE→ISSUE and the transition ISSUE→ISSUE are both taken when `req_valid` is high. The transition ISSUE→IDLE and the self-loop IDLE→IDLE are both taken when `req_valid` is low.

Top module: `mesh_route_select`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each edge that sampled `req_valid` high and is low otherwise. During and right after reset `out_valid`, `route_ok` and `route_sel` are zero.
- R2: Output vectors use bit 0 for local ejection, bit 1 for east (+x), bit 2 for west (−x), bit 3 for north (+y) and bit 4 for south (−y). When the destination equals the current node, both `route_ok` and `route_sel` are 5'b00001, whatever the mode and the busy flags.
- R3: With mode code 0 (dimension order), `route_ok` holds only the x direction toward the destination while an x offset remains, and otherwise holds only the y direction toward it.
- R4: With mode code 1 (west-first), a destination to the west gives west as the only permitted output. Otherwise every minimal direction among east, north and south is permitted.
- R5: With mode code 2 (north-last), north is permitted only once no x offset remains. All other minimal directions are permitted.
- R6: With mode code 3 (negative-first), while any west or south offset remains only the minimal west and south directions are permitted. Otherwise the minimal east and north directions are permitted.
- R7: With mode code 4 (odd-even), the heading input is coded 0 injected, 1 east, 2 west, 3 north, 4 south. In an even column with heading east, north and south are removed from the minimal set.
- R8: With mode code 4, in an odd column with heading north or south, west is removed from the minimal set. If nothing remains, `route_ok` and `route_sel` are both zero.
- R9: `busy` bits 0..3 flag east, west, north and south. `route_sel` is the first permitted direction that is not busy, in the order east, west, north, south.
- R10: When every permitted direction is busy, `route_sel` is the first permitted direction in that same order.
- R11: The unused mode codes 5, 6 and 7 behave as mode code 0.
- R12: When `out_valid` is high, `route_sel` has at most one bit set and that bit is also set in `route_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Turn policy code |
| heading | input | 3 | Direction of travel on arrival |
| cur_x | input | X_W | Current column |
| cur_y | input | Y_W | Current row |
| dst_x | input | X_W | Destination column |
| dst_y | input | Y_W | Destination row |
| busy | input | 4 | Busy flags for east, west, north, south |
| out_valid | output | 1 | Result valid |
| route_ok | output | 5 | Permitted minimal directions |
| route_sel | output | 5 | Chosen direction, one-hot or zero |

## Verification
The embedded properties assume that the mode and busy inputs seen at a request edge are the ones the result belongs to. They also assume that heading codes above 4 are never applied; the bench only drives codes 0 to 4. Headings are swept freely, including headings that no legal earlier hop could produce. Because of that, the blocked odd-even outcome of R8 is reached on purpose rather than being excluded. Coordinates stay in a 4×4 corner of the mesh, so every offset sign and both column parities occur under all five policies and one unused mode code.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    localparam int NDIR    = 5;
    localparam int NMESH   = NDIR - 1;
    localparam int P_LOCAL = 0;
    localparam int P_EAST  = 1;
    localparam int P_WEST  = 2;
    localparam int P_NORTH = 3;
    localparam int P_SOUTH = 4;

    typedef enum logic [2:0] {
        TM_XY        = 3'd0,
        TM_WESTFIRST = 3'd1,
        TM_NORTHLAST = 3'd2,
        TM_NEGFIRST  = 3'd3,
        TM_ODDEVEN   = 3'd4
    } turn_mode_e;

    typedef enum logic [2:0] {
        HD_INJECT = 3'd0,
        HD_EAST   = 3'd1,
        HD_WEST   = 3'd2,
        HD_NORTH  = 3'd3,
        HD_SOUTH  = 3'd4
    } heading_e;

    typedef enum logic {
        RS_IDLE,
        RS_ISSUE
    } rs_state_e;

endpackage

// File: rtl/mesh_route_cand.sv
module mesh_route_cand
    import mesh_route_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic [2:0]      mode,
    input  logic [2:0]      heading,
    input  logic [X_W-1:0]  cur_x,
    input  logic [Y_W-1:0]  cur_y,
    input  logic [X_W-1:0]  dst_x,
    input  logic [Y_W-1:0]  dst_y,
    output logic [NDIR-1:0] legal
);
    localparam logic [NDIR-1:0] M_LOCAL = NDIR'(1) << P_LOCAL;
    localparam logic [NDIR-1:0] M_EAST  = NDIR'(1) << P_EAST;
    localparam logic [NDIR-1:0] M_WEST  = NDIR'(1) << P_WEST;
    localparam logic [NDIR-1:0] M_NORTH = NDIR'(1) << P_NORTH;
    localparam logic [NDIR-1:0] M_SOUTH = NDIR'(1) << P_SOUTH;

    logic go_e, go_w, go_n, go_s, x_left, arrived;
    logic [NDIR-1:0] minimal;

    always_comb begin
        go_e    = dst_x > cur_x;
        go_w    = dst_x < cur_x;
        go_n    = dst_y > cur_y;
        go_s    = dst_y < cur_y;
        x_left  = go_e | go_w;
        arrived = !(x_left | go_n | go_s);
        minimal = (go_e ? M_EAST : '0) | (go_w ? M_WEST : '0)
                | (go_n ? M_NORTH : '0) | (go_s ? M_SOUTH : '0);

        legal = minimal;
        case (mode)
            TM_WESTFIRST: begin
                if (go_w) legal = M_WEST;
            end
            TM_NORTHLAST: begin
                if (x_left) legal = minimal & ~M_NORTH;
            end
            TM_NEGFIRST: begin
                if (go_w | go_s) legal = minimal & (M_WEST | M_SOUTH);
            end
            TM_ODDEVEN: begin
                if (!cur_x[0] && heading == HD_EAST)
                    legal = minimal & ~(M_NORTH | M_SOUTH);
                if (cur_x[0] && (heading == HD_NORTH || heading == HD_SOUTH))
                    legal = minimal & ~M_WEST;
            end
            default: begin
                if (x_left) legal = minimal & (M_EAST | M_WEST);
            end
        endcase

        if (arrived) legal = M_LOCAL;
    end
endmodule

// File: rtl/mesh_route_pick.sv
module mesh_route_pick
    import mesh_route_pkg::*;
#(
    parameter int N = NDIR
) (
    input  logic [N-1:0] legal,
    input  logic [N-1:0] busy_full,
    output logic [N-1:0] sel
);
    logic [N-1:0] free;
    logic [N-1:0] pool;
    logic [N:0]   seen;

    assign free    = legal & ~busy_full;
    assign pool    = (|free) ? free : legal;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_prio
        assign sel[i]    = pool[i] & ~seen[i];
        assign seen[i+1] = seen[i] | pool[i];
    end
endmodule

// File: rtl/mesh_route_select.sv
module mesh_route_select
    import mesh_route_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      mode,
    input  logic [2:0]      heading,
    input  logic [X_W-1:0]  cur_x,
    input  logic [Y_W-1:0]  cur_y,
    input  logic [X_W-1:0]  dst_x,
    input  logic [Y_W-1:0]  dst_y,
    input  logic [3:0]      busy,
    output logic            out_valid,
    output logic [4:0]      route_ok,
    output logic [4:0]      route_sel
);
    localparam logic [NDIR-1:0] M_LOCAL = NDIR'(1) << P_LOCAL;

    rs_state_e       state, state_nx;
    logic [NDIR-1:0] legal_c, sel_c, busy_full;

    assign busy_full = {busy, 1'b0};

    mesh_route_cand #(.X_W(X_W), .Y_W(Y_W)) u_cand (
        .mode(mode), .heading(heading),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .legal(legal_c)
    );

    mesh_route_pick #(.N(NDIR)) u_pick (
        .legal(legal_c), .busy_full(busy_full), .sel(sel_c)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            RS_IDLE:  state_nx = req_valid ? RS_ISSUE : RS_IDLE;
            RS_ISSUE: state_nx = req_valid ? RS_ISSUE : RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_ok  <= '0;
            route_sel <= '0;
        end else if (req_valid) begin
            route_ok  <= legal_c;
            route_sel <= sel_c;
        end
    end

    assign out_valid = (state == RS_ISSUE);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    assert_local_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && route_ok[P_LOCAL]) |-> (route_ok == M_LOCAL));
    assert_xy_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == TM_XY) |-> ($countones(route_ok) <= 1));
    assert_free_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ((route_ok & ~$past(busy_full)) != '0))
            |-> ((route_sel & $past(busy_full)) == '0));
    assert_sel_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(route_sel));
    assert_sel_subset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((route_sel & ~route_ok) == '0));
endmodule

// File: tb/mesh_route_select_test.sv
module mesh_route_select_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] mode = '0, heading = '0;
    logic [2:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic [3:0] busy = '0;
    logic       out_valid;
    logic [4:0] route_ok, route_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mesh_route_select uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .heading(heading), .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x),
        .dst_y(dst_y), .busy(busy), .out_valid(out_valid),
        .route_ok(route_ok), .route_sel(route_sel)
    );

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // bits: 0 local, 1 east, 2 west, 3 north, 4 south
    function automatic logic [4:0] ref_ok(int m, int cx, int cy, int tx, int ty, int hd);
        int ox = tx - cx;
        int oy = ty - cy;
        logic [4:0] all = 5'b0;
        logic [4:0] r;
        if (ox == 0 && oy == 0) return 5'b00001;
        if (ox > 0) all[1] = 1'b1;
        if (ox < 0) all[2] = 1'b1;
        if (oy > 0) all[3] = 1'b1;
        if (oy < 0) all[4] = 1'b1;
        r = all;
        if (m == 1) begin
            if (ox < 0) r = 5'b00100;
        end else if (m == 2) begin
            if (ox != 0) r[3] = 1'b0;
        end else if (m == 3) begin
            if (ox < 0 || oy < 0) r = all & 5'b10100;
        end else if (m == 4) begin
            if ((cx % 2) == 0 && hd == 1) begin r[3] = 1'b0; r[4] = 1'b0; end
            if ((cx % 2) == 1 && (hd == 3 || hd == 4)) r[2] = 1'b0;
        end else begin
            if (ox != 0) begin r[3] = 1'b0; r[4] = 1'b0; end
        end
        return r;
    endfunction

    function automatic logic [4:0] ref_sel(logic [4:0] ok, logic [3:0] b);
        if (ok[0]) return 5'b00001;
        for (int p = 1; p <= 4; p++)
            if (ok[p] && !b[p-1]) return 5'(1 << p);
        for (int p = 1; p <= 4; p++)
            if (ok[p]) return 5'(1 << p);
        return 5'b0;
    endfunction

    function automatic string tag_for(int m, int cx, int cy, int tx, int ty, int hd);
        if (cx == tx && cy == ty) return "R2";
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return ((cx % 2) == 0) ? "R7" : "R8";
            default: return "R11";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] eo;
        string t;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {4'b0, out_valid}, 5'b0);
        check("R1 reset ok", route_ok, 5'b0);
        check("R1 reset sel", route_sel, 5'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 idle valid", {4'b0, out_valid}, 5'b0);

        for (int m = 0; m < 6; m++)
        for (int cx = 0; cx < 4; cx++)
        for (int cy = 0; cy < 4; cy++)
        for (int tx = 0; tx < 4; tx++)
        for (int ty = 0; ty < 4; ty++)
        for (int hd = 0; hd < 5; hd++)
        for (int b = 0; b < 16; b += 5) begin
            @(negedge clk);
            req_valid = 1'b1;
            mode = 3'(m); heading = 3'(hd);
            cur_x = 3'(cx); cur_y = 3'(cy); dst_x = 3'(tx); dst_y = 3'(ty);
            busy = 4'(b);
            @(posedge clk); #1;
            eo = ref_ok(m, cx, cy, tx, ty, hd);
            t = tag_for(m, cx, cy, tx, ty, hd);
            check("R1 valid after request", {4'b0, out_valid}, 5'b00001);
            check({t, " permitted"}, route_ok, eo);
            check((b == 15) ? "R10 chosen when all busy" : "R9 chosen", route_sel,
                  ref_sel(eo, 4'(b)));
            if (eo == 5'b0) check("R8 blocked choice", route_sel, 5'b0);
        end

        // unused mode code 7 (R11) with a diagonal offset
        @(negedge clk);
        mode = 3'd7; heading = 3'd0; cur_x = 3'd1; cur_y = 3'd1;
        dst_x = 3'd6; dst_y = 3'd6; busy = 4'b0001;
        @(posedge clk); #1;
        check("R11 mode7 permitted", route_ok, 5'b00010);
        check("R11 mode7 chosen", route_sel, 5'b00010);

        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        check("R1 valid drops", {4'b0, out_valid}, 5'b0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule